// File: doc/BRIEF.md
# Saturating Shift-Left-Immediate Unit

This unit runs a saturating left shift by an immediate amount on packed lanes of a 128-bit operand. One immediate field encodes both the lane width and the shift count. A U bit and a 5-bit opcode choose one of three flavours:

- signed in, signed out;
- unsigned in, unsigned out;
- signed in, unsigned out.

A lane whose shifted value will not fit is clamped to the nearest limit of the target range. Any clamp in an active lane sets a sticky cumulative saturation flag.

A scalar form works on the lowest lane only and gives zero in every other lane. A 64-bit vector form (Q clear) gives zero in the upper half.

Operations enter on a valid/ready channel. Results leave, one per operation, on a second valid/ready channel through a single output register. Back-pressure rules:

- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- A result held with `out_ready` low stays unchanged until it is taken.

The flag is a plain status output with its own synchronous clear input.

Top module: `sqshl_unit`

## Requirements
- R1: The lane size code is the position of the highest set bit of `in_immh`, so bit 0 gives 8-bit lanes, bit 1 gives 16, bit 2 gives 32 and bit 3 gives 64. The shift amount is the 7-bit value {`in_immh`,`in_immb`} minus the lane width, which is 0 to width-1.
- R2: Opcode 5'b01110 with U=0 selects signed-to-signed, and with U=1 selects unsigned-to-unsigned. Opcode 5'b01100 with U=1 selects signed-to-unsigned.
- R3: Signed-to-signed clamps positive overflow to the lane's largest signed value and negative overflow to its smallest signed value, and reports saturation. A lane that fits gives the plain shifted value.
- R4: Unsigned-to-unsigned clamps overflow to all ones and reports saturation.
- R5: Signed-to-unsigned gives zero and reports saturation for any lane with its sign bit set, including at shift 0. A non-negative lane that overflows gives all ones and saturates.
- R6: With `in_scalar`=1 only lane 0 is processed. All other result lanes are zero and never cause saturation.
- R7: In vector form with `in_q`=0, result bits 127:64 are zero and those lanes never cause saturation. With `in_q`=1 every lane is processed.
- R8: `sat_flag` sets on the edge that accepts a defined operation with any saturating active lane. It stays set until an edge with `sat_clear`=1. When clear and a saturating accept come together, the flag ends set.
- R9: `in_immh`=0000, or any other U/opcode pairing (including opcode 01100 with U=0), is undefined. The output beat then carries `out_undef`=1, `out_result` keeps its previous value and `sat_flag` is not set by it.
- R10: `in_ready` = !`out_valid` | `out_ready`. `out_valid` is high in the cycle after an accept. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result` and `out_undef` hold. With `out_ready` high and no accept, `out_valid` drops.
- R11: After reset `out_valid`, `out_result`, `out_undef` and `sat_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_u | input | 1 | U bit of the operation |
| in_opcode | input | 5 | Operation opcode |
| in_immh | input | 4 | High part of the immediate (size and shift) |
| in_immb | input | 3 | Low part of the immediate |
| in_scalar | input | 1 | 1 = scalar form, lowest lane only |
| in_q | input | 1 | Vector form: 1 = 128 bits, 0 = lower 64 bits |
| in_src | input | 128 | Source operand |
| sat_clear | input | 1 | Synchronous clear of the saturation flag |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_result | output | 128 | Shifted, saturated result |
| out_undef | output | 1 | Beat belongs to an undefined encoding |
| sat_flag | output | 1 | Sticky cumulative saturation flag |

## Verification
The bench targets these corner cases:

- **Signed-to-unsigned at shift 0.** A negative lane must saturate even though no bits leave the lane. A design that only checks shifted-out bits returns the raw negative pattern with no flag.
- **Largest shift per lane size.** The top-lane boundary cases expose any off-by-one in the width subtraction or in the overflow window.
- **Scalar and 64-bit vector forms fed with saturating junk in the inactive lanes.** A design that fails to gate those lanes produces nonzero upper bits or a spurious flag.
- **Undefined encodings, stalls and a simultaneous clear-and-set.** These catch a result overwritten by an invalid beat, data that changes under back-pressure, and a clear that wins over a fresh saturation.

// File: rtl/sqshl_pkg.sv
package sqshl_pkg;

  typedef enum logic [1:0] {
    QV_SS = 2'd0,
    QV_UU = 2'd1,
    QV_SU = 2'd2
  } qvar_t;

  typedef struct packed {
    logic       undef;
    qvar_t      mode;
    logic [1:0] size;
    logic [5:0] shamt;
  } sqshl_dec_t;

  localparam logic [4:0] OPC_SAT_SHL = 5'b01110;
  localparam logic [4:0] OPC_SAT_SU  = 5'b01100;

endpackage

// File: rtl/sqshl_decode.sv
module sqshl_decode
  import sqshl_pkg::*;
(
  input  logic       u,
  input  logic [4:0] opcode,
  input  logic [3:0] immh,
  input  logic [2:0] immb,
  output sqshl_dec_t dec
);

  logic [6:0] imm_all;
  logic [6:0] lane_w;
  logic       opc_ok;
  qvar_t      mode_sel;

  assign imm_all = {immh, immb};

  always_comb begin
    opc_ok   = 1'b1;
    mode_sel = QV_SS;
    if (opcode == OPC_SAT_SHL) begin
      mode_sel = u ? QV_UU : QV_SS;
    end else if (opcode == OPC_SAT_SU && u) begin
      mode_sel = QV_SU;
    end else begin
      opc_ok = 1'b0;
    end
  end

  always_comb begin
    dec = '0;
    casez (immh)
      4'b1???: dec.size = 2'd3;
      4'b01??: dec.size = 2'd2;
      4'b001?: dec.size = 2'd1;
      default: dec.size = 2'd0;
    endcase
    lane_w    = 7'd8 << dec.size;
    dec.shamt = 6'(imm_all - lane_w);
    dec.mode  = mode_sel;
    dec.undef = ~opc_ok | (immh == 4'b0000);
  end

endmodule

// File: rtl/sqshl_lane.sv
module sqshl_lane
  import sqshl_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic [LW-1:0] src,
  input  logic [5:0]    shamt,
  input  qvar_t         mode,
  input  logic          active,
  output logic [LW-1:0] res,
  output logic          sat
);

  localparam int WW = 2 * LW;
  localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};

  logic [WW-1:0] sh_s;
  logic [WW-1:0] sh_u;
  logic          fit_s;
  logic          fit_u;
  logic          neg;
  logic [LW-1:0] raw_res;
  logic          raw_sat;

  assign neg   = src[LW-1];
  assign sh_s  = {{LW{neg}}, src} << shamt;
  assign sh_u  = {{LW{1'b0}}, src} << shamt;
  // signed fit: every bit from the new sign position upward agrees
  assign fit_s = (&sh_s[WW-1:LW-1]) | ~(|sh_s[WW-1:LW-1]);
  assign fit_u = ~(|sh_u[WW-1:LW]);

  always_comb begin
    raw_res = sh_u[LW-1:0];
    raw_sat = 1'b0;
    unique case (mode)
      QV_SS: begin
        raw_sat = ~fit_s;
        raw_res = fit_s ? sh_s[LW-1:0] : (neg ? SMIN : SMAX);
      end
      QV_UU: begin
        raw_sat = ~fit_u;
        raw_res = fit_u ? sh_u[LW-1:0] : '1;
      end
      QV_SU: begin
        if (neg) begin
          raw_sat = 1'b1;
          raw_res = '0;
        end else begin
          raw_sat = ~fit_u;
          raw_res = fit_u ? sh_u[LW-1:0] : '1;
        end
      end
      default: begin
        raw_sat = 1'b0;
        raw_res = '0;
      end
    endcase
  end

  assign res = active ? raw_res : '0;
  assign sat = active & raw_sat;

endmodule

// File: rtl/sqshl_lane_group.sv
module sqshl_lane_group
  import sqshl_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LW     = 8
) (
  input  logic [DATA_W-1:0] src,
  input  logic [5:0]        shamt,
  input  qvar_t             mode,
  input  logic              scalar,
  input  logic              q,
  output logic [DATA_W-1:0] res,
  output logic              sat
);

  localparam int NL   = DATA_W / LW;
  localparam int HALF = DATA_W / 2;

  logic [NL-1:0] lane_sat;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    localparam bit LOW_HALF = ((i * LW) < HALF);
    localparam bit FIRST    = (i == 0);
    logic act;
    assign act = scalar ? FIRST : (q | LOW_HALF);

    sqshl_lane #(.LW(LW)) u_lane (
      .src    (src[i*LW +: LW]),
      .shamt  (shamt),
      .mode   (mode),
      .active (act),
      .res    (res[i*LW +: LW]),
      .sat    (lane_sat[i])
    );
  end

  assign sat = |lane_sat;

endmodule

// File: rtl/sqshl_unit.sv
module sqshl_unit
  import sqshl_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_u,
  input  logic [4:0]        in_opcode,
  input  logic [3:0]        in_immh,
  input  logic [2:0]        in_immb,
  input  logic              in_scalar,
  input  logic              in_q,
  input  logic [DATA_W-1:0] in_src,
  input  logic              sat_clear,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_undef,
  output logic              sat_flag
);

  localparam int NSIZE = 4;
  localparam int HALF  = DATA_W / 2;

  sqshl_dec_t        dec;
  logic [DATA_W-1:0] grp_res [NSIZE];
  logic [NSIZE-1:0]  grp_sat;
  logic [DATA_W-1:0] op_res;
  logic              op_sat;
  logic              accept;

  sqshl_decode u_dec (
    .u      (in_u),
    .opcode (in_opcode),
    .immh   (in_immh),
    .immb   (in_immb),
    .dec    (dec)
  );

  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    sqshl_lane_group #(.DATA_W(DATA_W), .LW(8 << g)) u_grp (
      .src    (in_src),
      .shamt  (dec.shamt),
      .mode   (dec.mode),
      .scalar (in_scalar),
      .q      (in_q),
      .res    (grp_res[g]),
      .sat    (grp_sat[g])
    );
  end

  assign op_res   = grp_res[dec.size];
  assign op_sat   = grp_sat[dec.size];
  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_undef  <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_undef <= dec.undef;
      if (!dec.undef) out_result <= op_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sat_flag <= 1'b0;
    else        sat_flag <= (sat_flag & ~sat_clear) | (accept & ~dec.undef & op_sat);
  end

  // R10: a stalled beat must not move
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_undef));

  // R10: an accepted operation shows up on the next cycle
  p_accept_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8: sticky until cleared
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !sat_clear |=> sat_flag);

  // R8: clear without a saturating accept empties the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clear && !accept |=> !sat_flag);

  // R8: saturation sets the flag even against a clear
  p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !dec.undef && op_sat |=> sat_flag);

  // R9: undefined encodings leave the result alone
  p_undef_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dec.undef |=> out_undef && $stable(out_result));

  // R9: undefined encodings never raise the flag
  p_undef_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dec.undef && !sat_clear |=> $stable(sat_flag));

  // R7: half-width vector form clears the upper half
  p_q0_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !dec.undef && !in_scalar && !in_q |=> out_result[DATA_W-1:HALF] == '0);

  // R6: scalar form never writes the upper half
  p_scalar_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !dec.undef && in_scalar |=> out_result[DATA_W-1:HALF] == '0);

endmodule

// File: tb/sim_sqshl_unit.sv
`timescale 1ns/1ps
module sim_sqshl_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_u = 1'b0;
  logic [4:0]   in_opcode = '0;
  logic [3:0]   in_immh = '0;
  logic [2:0]   in_immb = '0;
  logic         in_scalar = 1'b0;
  logic         in_q = 1'b0;
  logic [127:0] in_src = '0;
  logic         sat_clear = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_result;
  logic         out_undef;
  logic         sat_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_tag = "R2";

  sqshl_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_u(in_u), .in_opcode(in_opcode), .in_immh(in_immh), .in_immb(in_immb),
    .in_scalar(in_scalar), .in_q(in_q), .in_src(in_src), .sat_clear(sat_clear),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_undef(out_undef), .sat_flag(sat_flag)
  );

  always #10 clk = ~clk;

  // behavioural reference of one operation, built from the requirements
  function automatic void ref_op(input logic u, input logic [4:0] opc,
      input logic [3:0] immh, input logic [2:0] immb, input logic sc, input logic q,
      input logic [127:0] src, output logic [127:0] res, output logic sat,
      output logic undef);
    int kind, sz, w, sh;
    logic [127:0] x, mask;
    logic signed [135:0] v, p, r, smax, smin, umax;
    res = '0; sat = 1'b0; undef = 1'b0; kind = 0;
    if (opc == 5'b01110) kind = u ? 1 : 0;
    else if (opc == 5'b01100 && u) kind = 2;
    else undef = 1'b1;
    if (immh == 4'b0000) undef = 1'b1;
    if (undef) return;
    sz = immh[3] ? 3 : immh[2] ? 2 : immh[1] ? 1 : 0;
    w  = 8 << sz;
    sh = int'({immh, immb}) - w;
    mask = (128'd1 << w) - 128'd1;
    umax = (136'sd1 <<< w) - 136'sd1;
    smax = (136'sd1 <<< (w - 1)) - 136'sd1;
    smin = -(136'sd1 <<< (w - 1));
    for (int i = 0; i < 128 / w; i++) begin
      if (sc && i != 0) continue;
      if (!sc && !q && i * w >= 64) continue;
      x = (src >> (i * w)) & mask;
      v = $signed({8'd0, x});
      if (kind != 1 && x[w-1]) v = v - (136'sd1 <<< w);
      p = v <<< sh;
      r = p;
      if (kind == 0) begin
        if (p > smax) begin r = smax; sat = 1'b1; end
        else if (p < smin) begin r = smin; sat = 1'b1; end
      end else if (kind == 2 && v < 0) begin
        r = '0; sat = 1'b1;
      end else if (p > umax) begin
        r = umax; sat = 1'b1;
      end
      res = res | ((r[127:0] & mask) << (i * w));
    end
  endfunction

  // cycle model of the output registers
  logic         m_valid = 0, m_undef = 0, m_flag = 0;
  logic [127:0] m_res = '0;
  string        m_tag = "R11";
  always @(posedge clk) begin
    logic [127:0] r; logic s, ud;
    if (!rst_n) begin
      m_valid <= 0; m_undef <= 0; m_flag <= 0; m_res <= '0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      ref_op(in_u, in_opcode, in_immh, in_immb, in_scalar, in_q, in_src, r, s, ud);
      m_valid <= 1; m_undef <= ud; m_tag <= cur_tag;
      if (!ud) m_res <= r;
      m_flag <= (m_flag & ~sat_clear) | (~ud & s);
    end else begin
      if (out_ready) m_valid <= 0;
      m_flag <= m_flag & ~sat_clear;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk(in_ready === (!m_valid || out_ready), "R10", "in_ready",
          128'(in_ready), 128'(!m_valid || out_ready));
      chk(out_valid === m_valid, "R10", "out_valid", 128'(out_valid), 128'(m_valid));
      chk(sat_flag === m_flag, "R8", "sat_flag", 128'(sat_flag), 128'(m_flag));
      if (m_valid) begin
        chk(out_undef === m_undef, m_undef ? "R9" : m_tag, "out_undef",
            128'(out_undef), 128'(m_undef));
        chk(out_result === m_res, m_undef ? "R9" : m_tag, "out_result", out_result, m_res);
      end
    end
  end

  task automatic send(input string tag, input logic u, input logic [4:0] opc,
      input logic [3:0] immh, input logic [2:0] immb, input logic sc, input logic q,
      input logic [127:0] src, input logic clr, input bit stall);
    bit taken = 0;
    @(negedge clk);
    cur_tag = tag;
    in_valid = 1; in_u = u; in_opcode = opc; in_immh = immh; in_immb = immb;
    in_scalar = sc; in_q = q; in_src = src; sat_clear = clr;
    while (!taken) begin
      out_ready = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      taken = in_ready;
      @(posedge clk);
      if (!taken) @(negedge clk);
    end
  endtask

  task automatic idle(input int n, input logic clr, input logic rdy);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0; sat_clear = clr; out_ready = rdy;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] rs;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(out_valid === 0, "R11", "reset out_valid", 128'(out_valid), 0);
    chk(out_result === '0, "R11", "reset out_result", out_result, 0);
    chk(out_undef === 0, "R11", "reset out_undef", 128'(out_undef), 0);
    chk(sat_flag === 0, "R11", "reset sat_flag", 128'(sat_flag), 0);

    // R1: each lane size, smallest and largest shift
    send("R1", 0, 5'b01110, 4'b0001, 3'd0, 0, 1, {16{8'h03}}, 0, 0);
    send("R1", 0, 5'b01110, 4'b0001, 3'd7, 0, 1, {16{8'h01}}, 0, 0);
    send("R1", 1, 5'b01110, 4'b0011, 3'd7, 0, 1, {8{16'h0001}}, 0, 0);
    send("R1", 1, 5'b01110, 4'b0111, 3'd7, 0, 1, {4{32'h0000_0001}}, 0, 0);
    send("R1", 1, 5'b01110, 4'b1111, 3'd7, 0, 1, {2{64'h1}}, 0, 0);
    send("R1", 0, 5'b01110, 4'b1010, 3'd5, 0, 1, {64'h0000_1234_5678_9abc, 64'hffff_ffff_ffff_fff0}, 0, 0);
    idle(2, 1, 1);
    // R3: signed clamps both ways
    send("R3", 0, 5'b01110, 4'b0001, 3'd1, 0, 1, {8{8'h40, 8'hA0}}, 0, 0);
    send("R3", 0, 5'b01110, 4'b0010, 3'd3, 0, 1, {4{16'h0800, 16'hF7FF, 16'hF000, 16'h0FFF}}, 0, 0);
    idle(1, 1, 1);
    // R4: unsigned clamp
    send("R4", 1, 5'b01110, 4'b0100, 3'd4, 0, 1, {32'h1000_0000, 32'h0FFF_FFFF, 32'h8000_0000, 32'h1}, 0, 0);
    idle(1, 1, 1);
    // R5: signed-to-unsigned, shift 0 with negative and positive lanes
    send("R5", 1, 5'b01100, 4'b0001, 3'd0, 0, 1, {8{8'h80, 8'h7F}}, 0, 0);
    send("R5", 1, 5'b01100, 4'b0001, 3'd1, 0, 1, {8{8'h40, 8'h3F}}, 0, 0);
    send("R5", 1, 5'b01100, 4'b1000, 3'd0, 0, 1, {64'hffff_ffff_ffff_ffff, 64'h7fff_ffff_ffff_ffff}, 0, 0);
    idle(1, 1, 1);
    // R6: scalar with saturating junk in other lanes
    send("R6", 0, 5'b01110, 4'b0001, 3'd4, 1, 1, {{15{8'h7F}}, 8'h01}, 0, 0);
    send("R6", 1, 5'b01100, 4'b0010, 3'd0, 1, 0, {{7{16'h8000}}, 16'h0123}, 0, 0);
    send("R6", 1, 5'b01110, 4'b1000, 3'd2, 1, 1, {64'hffff_ffff_ffff_ffff, 64'h0000_0000_0000_0011}, 0, 0);
    idle(1, 0, 1);
    chk(sat_flag === 0, "R6", "scalar no flag", 128'(sat_flag), 0);
    // R7: 64-bit vector form
    send("R7", 1, 5'b01110, 4'b0001, 3'd2, 0, 0, {{8{8'hFF}}, {8{8'h11}}}, 0, 0);
    idle(1, 0, 1);
    chk(sat_flag === 0, "R7", "q0 upper no flag", 128'(sat_flag), 0);
    send("R7", 1, 5'b01110, 4'b0001, 3'd2, 0, 1, {{8{8'hFF}}, {8{8'h11}}}, 0, 0);
    // R8: sticky, clear, clear together with set
    idle(3, 0, 1);
    send("R8", 1, 5'b01110, 4'b0001, 3'd0, 0, 1, {16{8'h05}}, 0, 0);
    idle(2, 1, 1);
    send("R8", 1, 5'b01110, 4'b0001, 3'd7, 0, 1, {16{8'h05}}, 1, 0);
    idle(2, 0, 1);
    // R9: undefined encodings
    send("R9", 0, 5'b01110, 4'b0000, 3'd5, 0, 1, {16{8'hFF}}, 0, 0);
    send("R9", 0, 5'b01100, 4'b0001, 3'd1, 0, 1, {16{8'h80}}, 0, 0);
    send("R9", 1, 5'b00000, 4'b0100, 3'd1, 0, 1, {16{8'h80}}, 0, 0);
    // R10: hold under back-pressure
    send("R10", 0, 5'b01110, 4'b0010, 3'd2, 0, 1, {8{16'h1234}}, 0, 0);
    idle(4, 0, 0);
    send("R10", 1, 5'b01110, 4'b0001, 3'd1, 0, 1, {16{8'h21}}, 0, 0);
    idle(2, 0, 1);
    // R2: random mix, variable back-pressure
    for (int n = 0; n < 600; n++) begin
      logic [4:0] opc;
      int pick = $urandom_range(0, 9);
      opc = (pick < 5) ? 5'b01110 : (pick < 9) ? 5'b01100 : 5'($urandom);
      rs = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(0, 1)) rs = rs & {16{8'h0F}};
      send("R2", 1'($urandom), opc, ($urandom_range(0, 15) == 0) ? 4'b0000 : 4'($urandom_range(1, 15)),
           3'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom), rs,
           1'($urandom_range(0, 7) == 0), 1);
    end
    idle(4, 0, 1);
    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule